// File: doc/BRIEF.md
# Door and Gap Request Safety Filter

This block sits on the path from the crew and environment request lines to the passenger door controller and to the controller of the retractable gap step. It takes five raw requests (two sources of "open door", "close door", "deploy gap step" and "withdraw gap step"). It reads four position sensors: door fully closed, door fully open, gap step fully withdrawn and gap step fully deployed. It hands a filtered copy of each request downstream.

The filter may only remove a request. It can never raise one. Every filtered line is its raw line ANDed with a per-lane permit bit. The permit bits are re-registered from the sensors on every clock. An open request is let through only while the gap step is reported fully deployed. A withdraw request is let through only while the door is reported fully closed. Requests may therefore arrive in any order: an open that comes before the step is out is held back until the sensors allow it. Close and deploy pass freely unless a parameter attaches a condition to them. A per-lane status bit reports every request that is being held back.

Top module: `door_gap_req_filter`

## Requirements
- R1: While reset is high, and in the cycle after it is released, every filtered output is 0 whatever the raw requests are. All permit bits reset to 0.
- R2: Passiveness. No filtered output bit is ever 1 while its raw input bit is 0.
- R3: `held[i]` equals `raw_req[i]` AND NOT `filt_req[i]` for every lane, in the same cycle.
- R4: Lanes 0 (external open) and 1 (internal open) pass their raw value only if, at the last clock edge, the gap-deployed sensor was 1 and the gap-withdrawn sensor was 0. Otherwise they are 0.
- R5: Lane 4 (withdraw gap) passes its raw value only if, at the last clock edge, the door-closed sensor was 1 and the door-open sensor was 0. Otherwise it is 0.
- R6: With default parameters, lane 2 (close) and lane 3 (deploy) equal their raw values from the first edge after reset onward, for every sensor pattern.
- R7: A sensor change affects the outputs exactly one clock edge later. A raw request change affects the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_req | input | 5 | Raw requests: bit0 external open, bit1 internal open, bit2 close, bit3 deploy gap, bit4 withdraw gap |
| sns_door_closed | input | 1 | Door fully closed sensor |
| sns_door_open | input | 1 | Door fully open sensor |
| sns_gap_in | input | 1 | Gap step fully withdrawn sensor |
| sns_gap_out | input | 1 | Gap step fully deployed sensor |
| filt_req | output | 5 | Filtered requests, same bit order as raw_req |
| held | output | 5 | Per-lane flag: raw request high but suppressed |

## Verification
The only internal state is the permit vector. A wrong permit bit shows at the ports one edge after the sensor pattern that produced it, as soon as its lane's raw request is high. Driving every raw pattern under every sensor pattern therefore exposes any corrupted permit within one cycle. Sampling again just before the next edge after a sensor change separates a missing register stage from a correct one.

// File: rtl/rqf_pkg.sv
package rqf_pkg;

    localparam int NLANE = 5;

    typedef enum int unsigned {
        LN_OPEN_EXT = 0,
        LN_OPEN_INT = 1,
        LN_CLOSE    = 2,
        LN_DEPLOY   = 3,
        LN_WITHDRAW = 4
    } lane_e;

    typedef struct packed {
        logic door_closed;
        logic door_open;
        logic gap_in;
        logic gap_out;
    } sensors_t;

    // Permission for each lane, derived from one sensor sample.
    function automatic logic [NLANE-1:0] lane_permits(
        input sensors_t s,
        input logic     gate_close,
        input logic     gate_deploy
    );
        logic [NLANE-1:0] p;
        logic open_ok;
        logic wd_ok;
        open_ok = s.gap_out & ~s.gap_in;
        wd_ok   = s.door_closed & ~s.door_open;
        p[LN_OPEN_EXT] = open_ok;
        p[LN_OPEN_INT] = open_ok;
        p[LN_CLOSE]    = gate_close  ? s.gap_out     : 1'b1;
        p[LN_DEPLOY]   = gate_deploy ? s.door_closed : 1'b1;
        p[LN_WITHDRAW] = wd_ok;
        return p;
    endfunction

endpackage

// File: rtl/rqf_permit_reg.sv
module rqf_permit_reg
    import rqf_pkg::*;
#(
    parameter bit GATE_CLOSE  = 1'b0,
    parameter bit GATE_DEPLOY = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  sensors_t         sns,
    output logic [NLANE-1:0] permit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            permit <= '0;
        end else begin
            permit <= lane_permits(sns, GATE_CLOSE, GATE_DEPLOY);
        end
    end

endmodule

// File: rtl/rqf_lane.sv
module rqf_lane (
    input  logic raw,
    input  logic permit,
    output logic filt,
    output logic held
);

    always_comb begin
        filt = raw & permit;
        held = raw & ~permit;
    end

endmodule

// File: rtl/door_gap_req_filter.sv
module door_gap_req_filter
    import rqf_pkg::*;
#(
    parameter bit GATE_CLOSE  = 1'b0,
    parameter bit GATE_DEPLOY = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NLANE-1:0] raw_req,
    input  logic             sns_door_closed,
    input  logic             sns_door_open,
    input  logic             sns_gap_in,
    input  logic             sns_gap_out,
    output logic [NLANE-1:0] filt_req,
    output logic [NLANE-1:0] held
);

    sensors_t         sns;
    logic [NLANE-1:0] permit;

    always_comb begin
        sns.door_closed = sns_door_closed;
        sns.door_open   = sns_door_open;
        sns.gap_in      = sns_gap_in;
        sns.gap_out     = sns_gap_out;
    end

    rqf_permit_reg #(
        .GATE_CLOSE  (GATE_CLOSE),
        .GATE_DEPLOY (GATE_DEPLOY)
    ) u_permit (
        .clk    (clk),
        .rst    (rst),
        .sns    (sns),
        .permit (permit)
    );

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        rqf_lane u_lane (
            .raw    (raw_req[i]),
            .permit (permit[i]),
            .filt   (filt_req[i]),
            .held   (held[i])
        );
    end

    // R1: first cycle out of reset lets nothing through
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (filt_req == '0));

    // R4: an open reaches the door only if the step was seen deployed
    assert_open_needs_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (filt_req[LN_OPEN_EXT] || filt_req[LN_OPEN_INT])
            |-> $past(sns_gap_out && !sns_gap_in));

    // R5: a withdraw reaches the step only if the door was seen closed
    assert_withdraw_needs_closed_R5: assert property (@(posedge clk) disable iff (rst)
        filt_req[LN_WITHDRAW] |-> $past(sns_door_closed && !sns_door_open));

    if (!GATE_DEPLOY) begin : g_deploy_free
        // R6: ungated deploy follows its raw line once out of reset
        assert_deploy_pass_R6: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (filt_req[LN_DEPLOY] == raw_req[LN_DEPLOY]));
    end

    if (!GATE_CLOSE) begin : g_close_free
        // R6: ungated close follows its raw line once out of reset
        assert_close_pass_R6: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (filt_req[LN_CLOSE] == raw_req[LN_CLOSE]));
    end

endmodule

// File: tb/door_gap_req_filter_bench.sv
module door_gap_req_filter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] raw_req = '0;
    logic       sns_door_closed = 1'b0;
    logic       sns_door_open   = 1'b0;
    logic       sns_gap_in      = 1'b0;
    logic       sns_gap_out     = 1'b0;
    logic [4:0] filt_req;
    logic [4:0] held;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    door_gap_req_filter u_door_gap_req_filter (
        .clk             (clk),
        .rst             (rst),
        .raw_req         (raw_req),
        .sns_door_closed (sns_door_closed),
        .sns_door_open   (sns_door_open),
        .sns_gap_in      (sns_gap_in),
        .sns_gap_out     (sns_gap_out),
        .filt_req        (filt_req),
        .held            (held)
    );

    // Sensor code: bit3 door closed, bit2 door open, bit1 gap in, bit0 gap out
    function automatic logic [4:0] exp_permit(input logic [3:0] s);
        logic [4:0] p;
        p[0] = s[0] & ~s[1];   // R4
        p[1] = s[0] & ~s[1];   // R4
        p[2] = 1'b1;           // R6
        p[3] = 1'b1;           // R6
        p[4] = s[3] & ~s[2];   // R5
        return p;
    endfunction

    task automatic set_sensors(input logic [3:0] s);
        sns_door_closed = s[3];
        sns_door_open   = s[2];
        sns_gap_in      = s[1];
        sns_gap_out     = s[0];
    endtask

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Full check of outputs for a given permit vector
    task automatic check_all(input string req, input logic [4:0] perm);
        check(req, filt_req, raw_req & perm);
        check("R2", filt_req & ~raw_req, 5'b0);
        check("R3", held, raw_req & ~filt_req);
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with permissive sensors and every request raised
        set_sensors(4'b1001);
        raw_req = 5'b11111;
        repeat (3) @(negedge clk);
        #1 check("R1", filt_req, 5'b0);
        check("R3", held, 5'b11111);
        @(negedge clk);
        rst = 1'b0;
        #1 check("R1", filt_req, 5'b0);
        @(negedge clk);
        #1 check("R7", filt_req, exp_permit(4'b1001));

        for (int s = 0; s < 16; s++) begin
            @(negedge clk);
            set_sensors(s[3:0]);
            @(negedge clk);
            for (int r = 0; r < 32; r++) begin
                raw_req = r[4:0];
                #1 check_all("R4_R5_R6", exp_permit(s[3:0]));
                @(negedge clk);
            end
            // R7: new sensors show only after the next edge
            raw_req = 5'b11111;
            set_sensors(4'(s + 5));
            #1 check_all("R7", exp_permit(s[3:0]));
            @(negedge clk);
            #1 check_all("R7", exp_permit(4'(s + 5)));
        end

        // R4: open raised before the step is out, then released once deployed
        set_sensors(4'b1010);
        raw_req = 5'b00001;
        @(negedge clk);
        #1 check("R4", filt_req, 5'b0);
        set_sensors(4'b1001);
        #1 check("R4", filt_req, 5'b0);
        @(negedge clk);
        #1 check("R4", filt_req, 5'b00001);

        // R1: reset again mid-run clears the permits
        rst = 1'b1;
        raw_req = 5'b11111;
        @(negedge clk);
        #1 check("R1", filt_req, 5'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule